// File: doc/BRIEF.md
# Command/Indication Channel Controller

This block terminates two short command/indication fields that travel once per frame on a time-division multiplexed link. A per-frame strobe marks the cycle in which the received bits of both channels are valid. On that strobe the block filters and stores the received codes, raises change flags, and drives one level interrupt while either flag is set. Transmit codes come from host-written registers and stay on the outputs until the host rewrites them.

Channel 0 carries a 4-bit code. A new channel-0 value is accepted only when the same value arrives in two consecutive frames, so a single corrupted frame cannot disturb the stored code. Channel 1 is 6 bits wide on the wire and runs in a narrow (4-bit) or wide (6-bit) mode. It accepts every received frame at once. In narrow mode the two upper received bits are stored but not compared, and the two upper transmitted bits are forced to 1. Reporting of channel-1 changes can be held back by an enable bit. A change seen while the enable is off is kept and shows up as soon as the enable returns.

The host reaches the block through a small register port. Read data is combinational from the address. A read of the status register with the read enable high clears both change flags at the next clock edge.

Top module: `ci_channel_ctrl`

## Requirements
- R1: After reset the stored channel-0 code reads 4'hF, the stored channel-1 code reads 6'h3F, both change flags and irq_o are 0, tx_ci0_o is 4'hF, tx_ci1_o is 6'h3F, and the channel-1 control holds narrow mode (0) with the change enable set (1).
- R2: A received channel-0 value that differs from the stored code, and that equals the value received in the previous frame, is loaded into the stored code on that strobe, and the channel-0 flag is set at the same clock edge.
- R3: A channel-0 value that appears in only one frame leaves the stored code and the channel-0 flag unchanged. Cycles without a strobe change nothing on either channel.
- R4: tx_ci0_o shows the value last written to register 2 bits [3:0], and it holds that value for every frame until the register is rewritten.
- R5: In narrow mode tx_ci1_o[5:4] is 2'b11 and tx_ci1_o[3:0] equals register 3 bits [3:0]. In wide mode tx_ci1_o equals register 3 bits [5:0].
- R6: On every strobe all six received channel-1 bits are stored. If any compared bit differs from the stored code and the enable is on, the channel-1 flag is set at that same edge, with no second frame needed.
- R7: In narrow mode (register 3 bit 6 = 0) a difference confined to received bits [5:4] does not set the channel-1 flag. In wide mode (bit 6 = 1) such a difference does set it.
- R8: While the channel-1 enable (register 3 bit 7) is 0, a channel-1 change does not set the flag. The change is kept pending, and the flag is set one clock after the enable is written to 1.
- R9: A read of register 0 (re_i high, addr_i = 0) clears both flags at the next clock edge, unless a flag-setting event for that flag happens in the same cycle, in which case that flag stays set.
- R10: irq_o is 1 exactly when at least one of the two change flags is set.
- R11: Register map. Address 0 is read-only: [3:0] channel-0 code, [4] channel-0 flag, [5] channel-1 flag, [7:6] zero. Address 1 is read-only: [5:0] channel-1 code, [7:6] zero. Address 2: [3:0] channel-0 transmit code, [7:4] read as zero. Address 3: [5:0] channel-1 transmit code, [6] wide mode, [7] channel-1 change enable. Writes to addresses 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Strobe: received bits are valid this cycle |
| rx_ci0_i | input | 4 | Received channel-0 bits |
| rx_ci1_i | input | 6 | Received channel-1 bits |
| tx_ci0_o | output | 4 | Transmitted channel-0 bits |
| tx_ci1_o | output | 6 | Transmitted channel-1 bits |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| we_i | input | 1 | Register write enable |
| re_i | input | 1 | Register read enable (a read of address 0 clears the flags) |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| irq_o | output | 1 | Level interrupt, high while any flag is set |

## Verification
The hardest case to reach is a status read landing in the same cycle as a flag-setting event. Channel 0 must be confirmed on exactly that strobe, or a pending channel-1 change must be released at that edge, or the read-clear and the set collide. The stimulus first steers channel 0 to a prepared candidate value. It then issues the confirming strobe with re_i high on address 0, and repeats the collision for channel 1 by holding a change pending while the enable is off. The reference model is updated every clock, so a wrong tie-break shows up both at the next read and on irq_o.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int unsigned CI0_W  = 4;
  localparam int unsigned CI1_W  = 6;
  localparam int unsigned CI1_NW = 4;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;

  localparam int unsigned ADDR_RX0 = 0;
  localparam int unsigned ADDR_RX1 = 1;
  localparam int unsigned ADDR_TX0 = 2;
  localparam int unsigned ADDR_TX1 = 3;

  typedef enum logic {
    CI1_NARROW = 1'b0,
    CI1_WIDE   = 1'b1
  } ci1_mode_e;
endpackage

// File: rtl/ci_ch0_rx.sv
module ci_ch0_rx #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame_i,
  input  logic [W-1:0] rx_i,
  output logic [W-1:0] code_o,
  output logic         chg_o
);
  logic [W-1:0] code_q;
  logic [W-1:0] cand_q;
  logic         confirm;

  // new value must match last frame's value and differ from stored code
  assign confirm = frame_i && (rx_i == cand_q) && (rx_i != code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '1;
      cand_q <= '1;
    end else if (frame_i) begin
      cand_q <= rx_i;
      if (confirm) code_q <= rx_i;
    end
  end

  assign code_o = code_q;
  assign chg_o  = confirm;

  AST_CH0_CONFIRMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |-> ($past(cand_q) == code_q)); // R2
  AST_CH0_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_i) |-> $stable(code_q)); // R3
endmodule

// File: rtl/ci_ch1_rx.sv
module ci_ch1_rx #(
  parameter int unsigned W  = 6,
  parameter int unsigned NW = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame_i,
  input  logic         wide_i,
  input  logic [W-1:0] rx_i,
  output logic [W-1:0] code_o,
  output logic         chg_o
);
  logic [W-1:0] code_q;
  logic [W-1:0] cmp_mask;

  for (genvar i = 0; i < int'(W); i++) begin : g_mask
    if (i < int'(NW)) begin : g_low
      assign cmp_mask[i] = 1'b1;
    end else begin : g_high
      assign cmp_mask[i] = wide_i;
    end
  end

  assign chg_o = frame_i && (|((rx_i ^ code_q) & cmp_mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= '1;
    else if (frame_i) code_q <= rx_i;
  end

  assign code_o = code_q;

  AST_CH1_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_i) |-> $stable(code_q)); // R6
endmodule

// File: rtl/ci_status.sv
module ci_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev0_i,
  input  logic ev1_i,
  input  logic en1_i,
  input  logic rd_clr_i,
  output logic f0_o,
  output logic f1_o,
  output logic irq_o
);
  localparam int unsigned NFLAG = 2;

  logic             pend_q;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] flag_q;

  assign set_v = {(ev1_i | pend_q) & en1_i, ev0_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q | ev1_i) & ~en1_i;
  end

  for (genvar g = 0; g < int'(NFLAG); g++) begin : g_flag
    // set wins over read-clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[g] <= 1'b0;
      else if (set_v[g])  flag_q[g] <= 1'b1;
      else if (rd_clr_i)  flag_q[g] <= 1'b0;
    end
  end

  assign f0_o  = flag_q[0];
  assign f1_o  = flag_q[1];
  assign irq_o = |flag_q;

  AST_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_clr_i && !ev0_i) |-> !f0_o); // R9
  AST_SET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ev0_i) |-> f0_o); // R9
  AST_NO_FLAG1_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en1_i) && !$past(f1_o)) |-> !f1_o); // R8
  AST_PEND_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pend_q && en1_i) |-> f1_o); // R8
endmodule

// File: rtl/ci_channel_ctrl.sv
module ci_channel_ctrl #(
  parameter int unsigned C0_W  = ci_pkg::CI0_W,
  parameter int unsigned C1_W  = ci_pkg::CI1_W,
  parameter int unsigned C1_NW = ci_pkg::CI1_NW,
  parameter int unsigned AW    = ci_pkg::REG_AW,
  parameter int unsigned DW    = ci_pkg::REG_DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_i,
  input  logic [C0_W-1:0] rx_ci0_i,
  input  logic [C1_W-1:0] rx_ci1_i,
  output logic [C0_W-1:0] tx_ci0_o,
  output logic [C1_W-1:0] tx_ci1_o,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            we_i,
  input  logic            re_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o
);
  import ci_pkg::*;

  localparam int unsigned WIDE_BIT = C1_W;
  localparam int unsigned EN_BIT   = C1_W + 1;
  localparam int unsigned F0_BIT   = C0_W;
  localparam int unsigned F1_BIT   = C0_W + 1;

  logic [C0_W-1:0] code0;
  logic [C1_W-1:0] code1;
  logic            ev0, ev1;
  logic            f0, f1;
  logic [C0_W-1:0] tx0_q;
  logic [C1_W-1:0] tx1_q;
  ci1_mode_e       mode_q;
  logic            en1_q;
  logic            wide;
  logic            sel_rx0, sel_tx0, sel_tx1;
  logic            rd_clr;

  assign sel_rx0 = (addr_i == AW'(ADDR_RX0));
  assign sel_tx0 = (addr_i == AW'(ADDR_TX0));
  assign sel_tx1 = (addr_i == AW'(ADDR_TX1));
  assign rd_clr  = re_i && sel_rx0;
  assign wide    = (mode_q == CI1_WIDE);

  ci_ch0_rx #(.W(C0_W)) u_ch0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .rx_i    (rx_ci0_i),
    .code_o  (code0),
    .chg_o   (ev0)
  );

  ci_ch1_rx #(.W(C1_W), .NW(C1_NW)) u_ch1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .wide_i  (wide),
    .rx_i    (rx_ci1_i),
    .code_o  (code1),
    .chg_o   (ev1)
  );

  ci_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev0_i    (ev0),
    .ev1_i    (ev1),
    .en1_i    (en1_q),
    .rd_clr_i (rd_clr),
    .f0_o     (f0),
    .f1_o     (f1),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx0_q  <= '1;
      tx1_q  <= '1;
      mode_q <= CI1_NARROW;
      en1_q  <= 1'b1;
    end else if (we_i) begin
      if (sel_tx0) tx0_q <= wdata_i[C0_W-1:0];
      if (sel_tx1) begin
        tx1_q  <= wdata_i[C1_W-1:0];
        mode_q <= ci1_mode_e'(wdata_i[WIDE_BIT]);
        en1_q  <= wdata_i[EN_BIT];
      end
    end
  end

  assign tx_ci0_o = tx0_q;

  for (genvar i = 0; i < int'(C1_W); i++) begin : g_tx1
    if (i < int'(C1_NW)) begin : g_low
      assign tx_ci1_o[i] = tx1_q[i];
    end else begin : g_high
      assign tx_ci1_o[i] = wide ? tx1_q[i] : 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_rx0) begin
      rdata_o[C0_W-1:0] = code0;
      rdata_o[F0_BIT]   = f0;
      rdata_o[F1_BIT]   = f1;
    end else if (addr_i == AW'(ADDR_RX1)) begin
      rdata_o[C1_W-1:0] = code1;
    end else if (sel_tx0) begin
      rdata_o[C0_W-1:0] = tx0_q;
    end else if (sel_tx1) begin
      rdata_o[C1_W-1:0] = tx1_q;
      rdata_o[WIDE_BIT] = wide;
      rdata_o[EN_BIT]   = en1_q;
    end
  end

  AST_TX0_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i && sel_tx0) |-> $stable(tx_ci0_o)); // R4
  AST_IRQ_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rdata_o[F0_BIT] || rdata_o[F1_BIT] || !sel_rx0)); // R10
endmodule

// File: tb/ci_channel_ctrl_bench.sv
module ci_channel_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic [3:0] rx0 = 4'h0;
  logic [5:0] rx1 = 6'h0;
  logic [3:0] tx0;
  logic [5:0] tx1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  logic [3:0] m_code0, m_cand0, m_tx0;
  logic [5:0] m_code1, m_tx1;
  logic m_f0, m_f1, m_pend, m_wide, m_en;

  always #5 clk = ~clk;

  ci_channel_ctrl u_ci_channel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .rx_ci0_i(rx0), .rx_ci1_i(rx1),
    .tx_ci0_o(tx0), .tx_ci1_o(tx1), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code0 = 4'hF; m_cand0 = 4'hF; m_code1 = 6'h3F;
      m_f0 = 0; m_f1 = 0; m_pend = 0;
      m_tx0 = 4'hF; m_tx1 = 6'h3F; m_wide = 0; m_en = 1;
    end else begin
      bit rdc, ev0, ev1, p, nf1;
      logic [5:0] msk;
      rdc = re && addr == 2'd0;
      ev0 = 0; ev1 = 0;
      if (frame) begin
        ev0 = (rx0 == m_cand0) && (rx0 != m_code0);
        msk = m_wide ? 6'h3F : 6'h0F;
        ev1 = ((rx1 ^ m_code1) & msk) != 6'h0;
      end
      p = m_pend || ev1;
      nf1 = (p && m_en) || (m_f1 && !rdc);
      m_pend = p && !m_en;
      m_f1 = nf1;
      m_f0 = ev0 || (m_f0 && !rdc);
      if (frame) begin
        if (ev0) m_code0 = rx0;
        m_cand0 = rx0;
        m_code1 = rx1;
      end
      if (we && addr == 2'd2) m_tx0 = wdata[3:0];
      if (we && addr == 2'd3) begin
        m_tx1 = wdata[5:0]; m_wide = wdata[6]; m_en = wdata[7];
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: exp_rd = {2'b00, m_f1, m_f0, m_code0};
      2'd1: exp_rd = {2'b00, m_code1};
      2'd2: exp_rd = {4'h0, m_tx0};
      default: exp_rd = {m_en, m_wide, m_tx1};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of transmit outputs and interrupt
  always begin
    @(posedge clk);
    #3;
    if (rst_n && !done) begin
      chk("R4 tx_ci0", {4'h0, tx0}, {4'h0, m_tx0});
      chk("R5 tx_ci1", {2'b00, tx1}, {2'b00, m_wide ? m_tx1 : {2'b11, m_tx1[3:0]}});
      chk("R10 irq", {7'h0, irq}, {7'h0, m_f0 || m_f1});
    end
  end

  task automatic step(input bit fr, input logic [3:0] c0, input logic [5:0] c1,
                      input bit rd, input bit wr, input logic [1:0] a, input logic [7:0] wd,
                      input string tag);
    @(negedge clk);
    frame = fr; rx0 = c0; rx1 = c1; re = rd; we = wr; addr = a; wdata = wd;
    #1;
    if (rd) chk(tag, rdata, exp_rd(a));
  endtask

  task automatic idle();
    step(0, 4'h0, 6'h0, 0, 0, 2'd0, 8'h0, "");
  endtask

  task automatic fr(input logic [3:0] c0, input logic [5:0] c1);
    step(1, c0, c1, 0, 0, 2'd0, 8'h0, "");
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(0, 4'h0, 6'h0, 1, 0, a, 8'h0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(0, 4'h0, 6'h0, 0, 1, a, d, "");
  endtask

  // peek without clearing
  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    frame = 0; re = 0; we = 0; addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state, R11 map
    peek(2'd0, 8'h0F, "R1 rx0 reset");
    peek(2'd1, 8'h3F, "R1 rx1 reset");
    peek(2'd2, 8'h0F, "R1 tx0 reset");
    peek(2'd3, 8'h bf, "R1 tx1 ctrl reset");
    chk("R1 irq reset", {7'h0, irq}, 8'h0);
    chk("R1 tx1 reset", {2'b00, tx1}, 8'h3F);

    // R3 single frame, R2 confirm
    fr(4'h5, 6'h3F);
    idle();
    peek(2'd0, 8'h0F, "R3 single frame no load");
    fr(4'h5, 6'h3F);
    idle();
    peek(2'd0, 8'h15, "R2 confirmed load and flag");
    chk("R10 irq after ch0", {7'h0, irq}, 8'h1);
    rd(2'd0, "R9 read status");
    idle();
    peek(2'd0, 8'h05, "R9 flags cleared by read");
    // glitch pattern 5,A,5
    fr(4'h5, 6'h3F); fr(4'hA, 6'h3F); fr(4'h5, 6'h3F);
    idle();
    peek(2'd0, 8'h05, "R3 glitch rejected");
    fr(4'hA, 6'h3F); fr(4'hA, 6'h3F);
    idle();
    peek(2'd0, 8'h1A, "R2 back-to-back confirm");
    rd(2'd0, "R9 clear");
    idle();

    // R6 channel 1 immediate
    fr(4'hA, 6'h32);
    idle();
    peek(2'd0, 8'h2A, "R6 ch1 flag one frame");
    peek(2'd1, 8'h32, "R6 ch1 stored");
    rd(2'd0, "R9 clear ch1");
    // R7 narrow: upper bits only
    fr(4'hA, 6'h02);
    idle();
    peek(2'd0, 8'h0A, "R7 narrow upper ignored");
    peek(2'd1, 8'h02, "R7 upper bits stored");
    // R11 writes to read-only ignored
    wr(2'd0, 8'hFF); wr(2'd1, 8'h00);
    idle();
    peek(2'd1, 8'h02, "R11 rx1 write ignored");
    peek(2'd0, 8'h0A, "R11 rx0 write ignored");
    // R5 tx narrow then wide
    wr(2'd2, 8'h03);
    wr(2'd3, 8'h85);
    idle();
    chk("R5 narrow tx1", {2'b00, tx1}, 8'h35);
    chk("R4 tx0 write", {4'h0, tx0}, 8'h03);
    repeat (3) fr(4'hA, 6'h02);
    chk("R4 tx0 held", {4'h0, tx0}, 8'h03);
    wr(2'd3, 8'hC5);
    idle();
    chk("R5 wide tx1", {2'b00, tx1}, 8'h05);
    // R7 wide: upper change flags
    fr(4'hA, 6'h12);
    idle();
    peek(2'd0, 8'h2A, "R7 wide upper flags");
    rd(2'd0, "R9 clear");
    // R8 disabled enable
    wr(2'd3, 8'h45);
    fr(4'hA, 6'h13);
    idle(); idle();
    peek(2'd0, 8'h0A, "R8 held back while disabled");
    wr(2'd3, 8'hC5);
    idle();
    peek(2'd0, 8'h2A, "R8 released on enable");
    rd(2'd0, "R9 clear");
    // R9 collision: ch0 confirm with read
    fr(4'h3, 6'h13);
    step(1, 4'h3, 6'h13, 1, 0, 2'd0, 8'h0, "R9 read during confirm");
    idle();
    peek(2'd0, 8'h13, "R9 set wins over clear ch0");
    rd(2'd0, "R9 clear");
    // R9 collision ch1: pending released while read
    wr(2'd3, 8'h45);
    fr(4'h3, 6'h14);
    wr(2'd3, 8'hC5);
    step(0, 4'h0, 6'h0, 1, 0, 2'd0, 8'h0, "R9 read at release");
    idle();
    peek(2'd0, 8'h23, "R9 set wins over clear ch1");
    rd(2'd0, "R9 final clear");
    idle();
    chk("R10 irq low", {7'h0, irq}, 8'h0);
    repeat (3) idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule